// File: doc/BRIEF.md
# Programmable Interval Down-Counter Timer

A 32-bit interval timer that software controls through a small word-addressed register bus. Its counter counts down by one on each clock-enable pulse from one of three tick sources, picked by a control field. When the counter leaves zero it either reloads from a programmable load register (periodic use) or wraps to all-ones and keeps going (free-running use, where software reads elapsed time as all-ones minus the counter).

A compare register marks one counter value. A sticky status flag latches when the counter passes that value, and an interrupt line reports the flag when interrupts are enabled. For one-shot use, software clears the enable bit after the event. For periodic use it leaves the timer running. An enable-mode option reloads the counter from the load register at the moment the timer is switched on. A self-clearing software reset returns every register to its reset value and holds the block idle for a fixed number of cycles.

Register offsets (byte addresses, bits 1:0 ignored):

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | status |
| 0x08 | load |
| 0x0C | compare |
| 0x10 | counter (read-only) |

Top module: `interval_downtimer`

## Requirements
- R1: After reset the registers read as follows: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0xFFFFFFFF. irq_o is low.
- R2: While control bit 0 (enable) is set, each pulse from the selected tick source lowers the counter by one.
- R3: A write to control that sets bit 0 while enable was clear, with bit 1 (enable mode) also set in that write, loads the counter from the load register. If bit 1 is clear, the counter keeps its value.
- R4: Control bits 25:24 pick the tick source: 1 selects tick_i[0], 2 selects tick_i[1] and 3 selects tick_i[2]. A value of 0 means no tick, so the counter does not move.
- R5: On a tick with the counter at zero and control bit 3 set, the counter reloads from the load register.
- R6: On a tick with the counter at zero and control bit 3 clear, the counter wraps to 0xFFFFFFFF.
- R7: Status bit 0 is set by a tick on which the counter, before it steps, equals the compare register. The bit then stays set. This holds for any load value of 2 or more.
- R8: Writing 1 to status bit 0 clears the bit and writing 0 leaves it as it is. When a flag-setting tick and a clearing write fall in the same cycle, the flag ends up set.
- R9: irq_o is high exactly when status bit 0 and control bit 2 (interrupt enable) are both set.
- R10: While enable is clear, ticks leave the counter unchanged.
- R11: Writing control with bit 16 set returns all registers to their reset values. Bit 16 then reads 1 for SRST_CYCLES cycles, bus writes are ignored during that time, and afterwards bit 16 reads 0.
- R12: Writes to the counter offset or to unmapped offsets have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| tick_i | input | 3 | Clock-enable pulses from the three tick sources |
| irq_o | output | 1 | Compare interrupt |

## Verification
On every cycle, the embedded assertions check how the counter steps: decrement, reload or wrap at zero, and hold while disabled. They also check that the flag stays set, that a set and a clear in the same cycle leave the flag set, that the interrupt follows the flag, and that the block stays idle during a software reset. Only the directed scenarios can show the rest, because each of these depends on a particular sequence of bus writes: the reset register values, reload at enable with and without enable mode, tick-source selection including the off setting, the flag timing with a load value of 2, write-one-to-clear, and the bus-visible results of a software reset.

// File: rtl/interval_downtimer.sv
module interval_downtimer #(
  parameter int SRST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic [4:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic [2:0]  tick_i,
  output logic        irq_o
);
  localparam int RW = $clog2(SRST_CYCLES + 1);
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic          en_q, enmod_q, ie_q, rld_q, flag_q;
  logic [1:0]    src_q;
  logic [31:0]   load_q, cmp_q, cnt_q;
  logic [RW-1:0] srst_q;
  logic          tick_sel;

  wire busy     = (srst_q != '0);
  wire wr_ok    = bus_wr_i && !busy;
  wire wr_ctrl  = wr_ok && (bus_addr_i[4:2] == 3'd0);
  wire wr_stat  = wr_ok && (bus_addr_i[4:2] == 3'd1);
  wire wr_load  = wr_ok && (bus_addr_i[4:2] == 3'd2);
  wire wr_cmp   = wr_ok && (bus_addr_i[4:2] == 3'd3);
  wire do_srst  = wr_ctrl && bus_wdata_i[16];
  wire start    = wr_ctrl && bus_wdata_i[0] && bus_wdata_i[1] && !en_q;

  always_comb begin
    case (src_q)
      2'd1:    tick_sel = tick_i[0];
      2'd2:    tick_sel = tick_i[1];
      2'd3:    tick_sel = tick_i[2];
      default: tick_sel = 1'b0;
    endcase
  end

  wire        step     = en_q && tick_sel && !busy;
  wire        hit      = step && (cnt_q == cmp_q);
  wire [31:0] cnt_next = (cnt_q == '0) ? (rld_q ? load_q : ONES) : cnt_q - 32'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {en_q, enmod_q, ie_q, rld_q, flag_q} <= '0;
      src_q  <= '0;
      load_q <= ONES;
      cmp_q  <= '0;
      cnt_q  <= ONES;
      srst_q <= '0;
    end else if (do_srst) begin
      {en_q, enmod_q, ie_q, rld_q, flag_q} <= '0;
      src_q  <= '0;
      load_q <= ONES;
      cmp_q  <= '0;
      cnt_q  <= ONES;
      srst_q <= RW'(SRST_CYCLES);
    end else begin
      if (busy) srst_q <= srst_q - 1'b1;
      if (wr_ctrl) begin
        en_q    <= bus_wdata_i[0];
        enmod_q <= bus_wdata_i[1];
        ie_q    <= bus_wdata_i[2];
        rld_q   <= bus_wdata_i[3];
        src_q   <= bus_wdata_i[25:24];
      end
      if (wr_load) load_q <= bus_wdata_i;
      if (wr_cmp)  cmp_q  <= bus_wdata_i;
      if (start)     cnt_q <= load_q;
      else if (step) cnt_q <= cnt_next;
      if (hit)                          flag_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr_i[4:2])
      3'd0:    bus_rdata_o = {6'd0, src_q, 7'd0, busy, 12'd0, rld_q, ie_q, enmod_q, en_q};
      3'd1:    bus_rdata_o = {31'd0, flag_q};
      3'd2:    bus_rdata_o = load_q;
      3'd3:    bus_rdata_o = cmp_q;
      3'd4:    bus_rdata_o = cnt_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & ie_q;

  // R2
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_ctrl && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 32'd1);
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_ctrl && cnt_q == '0 && rld_q) |=> cnt_q == $past(load_q));
  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_ctrl && cnt_q == '0 && !rld_q) |=> cnt_q == ONES);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_ctrl) |=> $stable(cnt_q));
  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_stat && bus_wdata_i[0]) && !do_srst) |=> flag_q);
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !do_srst) |=> flag_q);
  // R9
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q && ie_q));
  // R11
  srst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (!en_q && !flag_q));
endmodule

// File: tb/interval_downtimer_tb_top.sv
`timescale 1ns/1ps
module interval_downtimer_tb_top;
  localparam int SRST = 4;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10, A_BAD = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, irq;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] tick = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  interval_downtimer #(.SRST_CYCLES(SRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(logic [2:0] t, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = t;
      @(negedge clk); tick = '0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1", A_CTRL, 32'h0);
    rd_chk("R1", A_STAT, 32'h0);
    rd_chk("R1", A_LOAD, 32'hFFFFFFFF);
    rd_chk("R1", A_CMP, 32'h0);
    rd_chk("R1", A_CNT, 32'hFFFFFFFF);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_periodic;
    wr_reg(A_LOAD, 32'd5);
    wr_reg(A_CTRL, 32'h0100000B);
    rd_chk("R3 start", A_CNT, 32'd5);
    pulse(3'b001, 2);
    rd_chk("R2", A_CNT, 32'd3);
    pulse(3'b010, 1);
    rd_chk("R4 other src", A_CNT, 32'd3);
    pulse(3'b001, 3);
    rd_chk("R2 zero", A_CNT, 32'd0);
    rd_chk("R7 not yet", A_STAT, 32'd0);
    pulse(3'b001, 1);
    rd_chk("R5", A_CNT, 32'd5);
    rd_chk("R7", A_STAT, 32'd1);
    chk("R9 masked", irq, 1'b0);
    wr_reg(A_CTRL, 32'h0100000F);
    chk("R9 on", irq, 1'b1);
    rd_chk("R3 no restart", A_CNT, 32'd5);
    wr_reg(A_STAT, 32'd0);
    rd_chk("R8 write0", A_STAT, 32'd1);
    wr_reg(A_STAT, 32'd1);
    rd_chk("R8 clear", A_STAT, 32'd0);
    chk("R9 off", irq, 1'b0);
    wr_reg(A_CMP, 32'd5);
    @(negedge clk); wr = 1'b1; addr = A_STAT; wdata = 32'd1; tick = 3'b001;
    @(negedge clk); wr = 1'b0; tick = '0;
    rd_chk("R8 set wins", A_STAT, 32'd1);
    rd_chk("R2", A_CNT, 32'd4);
  endtask

  task automatic t_freerun;
    wr_reg(A_CTRL, 32'h01000000);
    pulse(3'b001, 2);
    rd_chk("R10", A_CNT, 32'd4);
    wr_reg(A_LOAD, 32'd7);
    wr_reg(A_CTRL, 32'h01000001);
    rd_chk("R3 no enmod", A_CNT, 32'd4);
    pulse(3'b001, 4);
    rd_chk("R2", A_CNT, 32'd0);
    pulse(3'b001, 1);
    rd_chk("R6", A_CNT, 32'hFFFFFFFF);
  endtask

  task automatic t_load2;
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_STAT, 32'd1);
    wr_reg(A_CMP, 32'd1);
    wr_reg(A_LOAD, 32'd2);
    wr_reg(A_CTRL, 32'h0200000B);
    rd_chk("R3", A_CNT, 32'd2);
    pulse(3'b010, 1);
    rd_chk("R7 load2", A_STAT, 32'd0);
    pulse(3'b010, 1);
    rd_chk("R7 load2", A_STAT, 32'd1);
    rd_chk("R7 load2", A_CNT, 32'd0);
    wr_reg(A_STAT, 32'd1);
    pulse(3'b010, 2);
    rd_chk("R5 load2", A_CNT, 32'd1);
    rd_chk("R7 period", A_STAT, 32'd0);
    pulse(3'b010, 1);
    rd_chk("R7 period", A_STAT, 32'd1);
  endtask

  task automatic t_src_off;
    wr_reg(A_CTRL, 32'h00000008);
    wr_reg(A_CTRL, 32'h0000000B);
    rd_chk("R3", A_CNT, 32'd2);
    pulse(3'b111, 3);
    rd_chk("R4 off", A_CNT, 32'd2);
    wr_reg(A_CNT, 32'd0);
    rd_chk("R12 cnt ro", A_CNT, 32'd2);
    wr_reg(A_BAD, 32'hFFFFFFFF);
    rd_chk("R12 unmapped", A_BAD, 32'd0);
    rd_chk("R12 ctrl kept", A_CTRL, 32'h0000000B);
  endtask

  task automatic t_srst;
    wr_reg(A_LOAD, 32'h1234);
    wr_reg(A_CTRL, 32'h0101000F);
    rd_chk("R11 busy", A_CTRL, 32'h00010000);
    rd_chk("R11 load", A_LOAD, 32'hFFFFFFFF);
    rd_chk("R11 flag", A_STAT, 32'd0);
    wr_reg(A_LOAD, 32'h55);
    repeat (SRST - 3) @(negedge clk);
    rd_chk("R11 still busy", A_CTRL, 32'h00010000);
    @(negedge clk);
    rd_chk("R11 done", A_CTRL, 32'h0);
    rd_chk("R11 write ignored", A_LOAD, 32'hFFFFFFFF);
    rd_chk("R11 cnt", A_CNT, 32'hFFFFFFFF);
    chk("R11 irq", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_freerun();
    t_load2();
    t_src_off();
    t_srst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule